// File: doc/BRIEF.md
# Framed Serial Transmitter with Frame-Sync Error Detection

This block sends fixed-length words serially, most significant bit first, on a single data line clocked by the bit clock. A host loads each word into a holding register. When a frame-sync pulse opens a frame, the word moves into a shift register. The first data bit appears after a programmable data delay of zero, one or two bit clocks. Because the register is double-buffered, the host can load the next word while the current one is still being shifted out.

A frame-sync pulse can arrive while a frame is still in flight, and the block classes it as unexpected. A configuration bit selects what happens next. In one setting the pulse is dropped and the frame runs to its end. In the other, the block restarts the same word from its first bit, after the same data delay, and raises a sticky error flag. An interrupt request either reports such errors or signals that the holding register has emptied, as selected by a 2-bit mode field.

Top module: `framed_ser_tx`

## Requirements
- R1: After reset, dx_o is 0, ready_o is 1, sync_err_o is 0 and irq_o is 0.
- R2: A host write makes ready_o read 0 from the next cycle. A frame start that finds the holding register full copies the word, and ready_o reads 1 from the cycle after that frame-sync edge.
- R3: A frame sends W bits, MSB first, one per clock. Bit k is on dx_o in cycle d+k after the frame-sync edge, where d is 0, 1 or 2 from cfg_delay_i. Delay code 3 behaves as 2. Outside a frame dx_o is 0.
- R4: A frame-sync pulse is a normal frame start, with no error, when the transmitter is idle or when it coincides with the edge that ends the last bit. This includes the first pulse after enable.
- R5: With cfg_ignore_i at 0, a frame-sync pulse during the delay or before the last bit ends restarts the same word from its MSB with the same delay. It sets sync_err_o and leaves ready_o unchanged.
- R6: With cfg_ignore_i at 1, such a pulse has no effect: the frame completes unchanged and sync_err_o stays 0.
- R7: sync_err_o stays set until err_clr_i is 1 at a clock edge, or until tx_en_i is 0 at a clock edge.
- R8: With cfg_irq_mode_i equal to 2'b11, irq_o pulses for one cycle in each cycle that follows an edge that restarts a frame on an error. It does not pulse when ready_o rises.
- R9: With any other cfg_irq_mode_i value, irq_o pulses for one cycle in the cycle in which ready_o rises.
- R10: A frame start that finds the holding register empty resends the last word sent. ready_o stays 1 and no irq_o pulse occurs.
- R11: tx_en_i at 0 at a clock edge aborts any frame, empties the holding register and clears sync_err_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmitter enable; 0 holds the transmitter in reset |
| cfg_delay_i | input | 2 | Data delay in bit clocks (0, 1, 2; 3 acts as 2) |
| cfg_ignore_i | input | 1 | 1 drops unexpected frame-sync pulses |
| cfg_irq_mode_i | input | 2 | 2'b11: interrupt on sync error; other values: on ready |
| wr_en_i | input | 1 | Host write strobe to the holding register |
| wr_data_i | input | W | Host write data |
| err_clr_i | input | 1 | Host write of 0 to the sync-error flag |
| fs_i | input | 1 | Frame-sync pulse, sampled at the clock edge |
| dx_o | output | 1 | Serial data out |
| ready_o | output | 1 | Holding register empty |
| sync_err_o | output | 1 | Sticky frame-sync error flag |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
Every result is registered once after the edge that samples its cause. ready_o, sync_err_o and irq_o change in the cycle after the write or frame-sync edge. Bit k of a frame appears d+k cycles after the frame-sync edge, and after a restart that count begins again at the restarting edge. The bench drives inputs on the falling edge and reads outputs on the next falling edge. It computes each expected bit from the frame-sync position, the delay and the word, so each compare falls in exactly the cycle the requirement names.

// File: rtl/fstx_pkg.sv
package fstx_pkg;
  localparam logic [1:0] IRQ_ON_ERR = 2'b11;

  // delay code 3 saturates to 2
  function automatic logic [1:0] eff_delay(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction
endpackage

// File: rtl/fstx_hold.sv
module fstx_hold #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tx_en_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         copy_i,
  output logic [W-1:0] hold_o,
  output logic         full_o,
  output logic         ready_o,
  output logic         ready_rise_o
);
  logic [W-1:0] hold_q;
  logic         full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      full_q <= 1'b0;
    end else if (!tx_en_i) begin
      full_q <= 1'b0;
    end else begin
      if (wr_en_i) hold_q <= wr_data_i;
      if (wr_en_i)     full_q <= 1'b1;
      else if (copy_i) full_q <= 1'b0;
    end
  end

  assign hold_o       = hold_q;
  assign full_o       = full_q;
  assign ready_o      = ~full_q;
  assign ready_rise_o = tx_en_i & copy_i & full_q & ~wr_en_i;

  p_ready_low_after_wr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && wr_en_i) |=> !ready_o);
endmodule

// File: rtl/fstx_frame_ctrl.sv
module fstx_frame_ctrl #(
  parameter int W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tx_en_i,
  input  logic       fs_i,
  input  logic [1:0] delay_i,
  input  logic       ignore_i,
  output logic       start_o,
  output logic       unexp_o,
  output logic       restart_o,
  output logic       load_o,
  output logic       shift_en_o,
  output logic       active_o
);
  import fstx_pkg::*;
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic          act_q, pend_q;
  logic [CW-1:0] cnt_q;
  logic [1:0]    dcnt_q, dly;
  logic          busy, done;

  assign dly  = eff_delay(delay_i);
  assign busy = act_q | pend_q;
  assign done = act_q & (cnt_q == LAST);

  // a pulse on the edge that ends the last bit opens a new frame
  assign unexp_o    = fs_i & busy & ~done;
  assign start_o    = fs_i & ~(busy & ~done);
  assign restart_o  = unexp_o & ~ignore_i;
  assign load_o     = start_o | restart_o;
  assign shift_en_o = act_q & ~done;
  assign active_o   = act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      dcnt_q <= '0;
    end else if (!tx_en_i) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      dcnt_q <= '0;
    end else if (load_o) begin
      cnt_q  <= '0;
      dcnt_q <= dly;
      act_q  <= (dly == 2'd0);
      pend_q <= (dly != 2'd0);
    end else if (pend_q) begin
      dcnt_q <= dcnt_q - 2'd1;
      if (dcnt_q == 2'd1) begin
        pend_q <= 1'b0;
        act_q  <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (act_q) begin
      if (done) act_q <= 1'b0;
      else      cnt_q <= cnt_q + CW'(1);
    end
  end

  p_no_overlap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(act_q && pend_q));
  p_restart_zero_delay_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && restart_o && delay_i == 2'd0) |=> (act_q && cnt_q == '0));
endmodule

// File: rtl/fstx_shifter.sv
module fstx_shifter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tx_en_i,
  input  logic         start_i,
  input  logic         load_i,
  input  logic         new_valid_i,
  input  logic [W-1:0] hold_i,
  input  logic         shift_en_i,
  input  logic         active_i,
  output logic         dx_o
);
  logic [W-1:0] word_q, shift_q, next_word;

  // restart or empty holding register reuses the frame word
  assign next_word = (start_i && new_valid_i) ? hold_i : word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      shift_q <= '0;
    end else if (tx_en_i) begin
      if (load_i) begin
        word_q  <= next_word;
        shift_q <= next_word;
      end else if (shift_en_i) begin
        shift_q <= {shift_q[W-2:0], 1'b0};
      end
    end
  end

  assign dx_o = active_i & shift_q[W-1];
endmodule

// File: rtl/fstx_sync_err.sv
module fstx_sync_err (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tx_en_i,
  input  logic       err_evt_i,
  input  logic       clr_i,
  input  logic [1:0] irq_mode_i,
  input  logic       ready_rise_i,
  output logic       err_o,
  output logic       irq_o
);
  import fstx_pkg::*;
  logic err_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
      irq_q <= 1'b0;
    end else if (!tx_en_i) begin
      err_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (err_evt_i)  err_q <= 1'b1;
      else if (clr_i) err_q <= 1'b0;
      irq_q <= (irq_mode_i == IRQ_ON_ERR) ? err_evt_i : ready_rise_i;
    end
  end

  assign err_o = err_q;
  assign irq_o = irq_q;

  p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && tx_en_i && !clr_i) |=> err_q);
  p_irq_on_err_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(err_q) && $past(irq_mode_i) == IRQ_ON_ERR) |-> irq_q);
endmodule

// File: rtl/framed_ser_tx.sv
module framed_ser_tx #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tx_en_i,
  input  logic [1:0]   cfg_delay_i,
  input  logic         cfg_ignore_i,
  input  logic [1:0]   cfg_irq_mode_i,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         err_clr_i,
  input  logic         fs_i,
  output logic         dx_o,
  output logic         ready_o,
  output logic         sync_err_o,
  output logic         irq_o
);
  logic [W-1:0] hold;
  logic full, ready_rise;
  logic start, unexp, restart, load, shift_en, active;

  fstx_hold #(.W(W)) u_hold (
    .clk_i, .rst_ni, .tx_en_i, .wr_en_i, .wr_data_i,
    .copy_i(start), .hold_o(hold), .full_o(full),
    .ready_o, .ready_rise_o(ready_rise)
  );

  fstx_frame_ctrl #(.W(W)) u_ctrl (
    .clk_i, .rst_ni, .tx_en_i, .fs_i,
    .delay_i(cfg_delay_i), .ignore_i(cfg_ignore_i),
    .start_o(start), .unexp_o(unexp), .restart_o(restart),
    .load_o(load), .shift_en_o(shift_en), .active_o(active)
  );

  fstx_shifter #(.W(W)) u_shift (
    .clk_i, .rst_ni, .tx_en_i, .start_i(start), .load_i(load),
    .new_valid_i(full), .hold_i(hold), .shift_en_i(shift_en),
    .active_i(active), .dx_o
  );

  fstx_sync_err u_err (
    .clk_i, .rst_ni, .tx_en_i, .err_evt_i(restart), .clr_i(err_clr_i),
    .irq_mode_i(cfg_irq_mode_i), .ready_rise_i(ready_rise),
    .err_o(sync_err_o), .irq_o
  );

  p_restart_keeps_ready_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && unexp && !wr_en_i) |=> $stable(ready_o));
endmodule

// File: tb/framed_ser_tx_tb_top.sv
module framed_ser_tx_tb_top;
  localparam int W = 8;
  localparam time CLK_PERIOD = 10ns;

  logic clk_i = 1'b0, rst_ni = 1'b0, tx_en_i = 1'b0;
  logic [1:0] cfg_delay_i = '0, cfg_irq_mode_i = '0;
  logic cfg_ignore_i = 1'b0, wr_en_i = 1'b0, err_clr_i = 1'b0, fs_i = 1'b0;
  logic [W-1:0] wr_data_i = '0;
  logic dx_o, ready_o, sync_err_o, irq_o;
  int n_run = 0, n_fail = 0;

  framed_ser_tx #(.W(W)) dut_i (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // fields: word[18:11] delay[10:9] ignore[8] mode[7:6] glitch_tick[5:1] write[0]
  localparam int NV = 9;
  localparam logic [18:0] VEC [NV] = '{
    {8'hA5, 2'd0, 1'b0, 2'd0, 5'd0, 1'b1},
    {8'h3C, 2'd1, 1'b0, 2'd0, 5'd0, 1'b1},
    {8'hC3, 2'd2, 1'b0, 2'd1, 5'd0, 1'b1},
    {8'h96, 2'd3, 1'b0, 2'd2, 5'd0, 1'b1},
    {8'h5A, 2'd0, 1'b0, 2'd3, 5'd3, 1'b1},
    {8'hE1, 2'd2, 1'b1, 2'd3, 5'd4, 1'b1},
    {8'h71, 2'd1, 1'b0, 2'd0, 5'd5, 1'b1},
    {8'h0F, 2'd0, 1'b0, 2'd0, 5'd8, 1'b1},
    {8'h0F, 2'd1, 1'b0, 2'd1, 5'd0, 1'b0}
  };

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_case(input logic [W-1:0] word, input int d, input bit ign,
                          input int mode, input int m, input bit wr);
    int de, rs, last, base, rel, ebit, eirq, eerr;
    bit gerr, eff;
    string req;
    de = (d == 3) ? 2 : d;
    cfg_delay_i = 2'(d); cfg_ignore_i = ign; cfg_irq_mode_i = 2'(mode);
    tx_en_i = 1'b0; tick(); tx_en_i = 1'b1;
    chk("R11", "err after disable", int'(sync_err_o), 0);
    if (wr) begin
      wr_en_i = 1'b1; wr_data_i = word; tick(); wr_en_i = 1'b0;
      chk("R2", "ready after write", int'(ready_o), 0);
    end
    gerr = (m != 0) && (m < de + W) && !ign;
    eff  = (m != 0) && ((m >= de + W) || !ign);
    rs   = eff ? m : 0;
    last = rs + de + W + 1;
    req  = !wr ? "R10" : gerr ? "R5" : (m != 0 && ign) ? "R6" : (m != 0) ? "R4" : "R3";
    for (int i = 0; i <= last; i++) begin
      fs_i = (i == 0) || (m != 0 && i == m);
      tick();
      fs_i = 1'b0;
      base = (i >= rs) ? rs : 0;
      rel  = i - base;
      ebit = (rel >= de && rel < de + W) ? int'(word[W-1-(rel-de)]) : 0;
      eirq = (mode == 3) ? int'(gerr && i == m) : int'(wr && i == 0);
      eerr = int'(gerr && i >= m);
      chk(req, "dx", int'(dx_o), ebit);
      chk(mode == 3 ? "R8" : "R9", "irq", int'(irq_o), eirq);
      chk(gerr ? "R7" : req, "sync_err", int'(sync_err_o), eerr);
      if (i == 0) chk(wr ? "R2" : "R10", "ready after fs", int'(ready_o), 1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(); tick();
    chk("R1", "dx in reset", int'(dx_o), 0);
    chk("R1", "ready in reset", int'(ready_o), 1);
    chk("R1", "err in reset", int'(sync_err_o), 0);
    chk("R1", "irq in reset", int'(irq_o), 0);
    rst_ni = 1'b1; tx_en_i = 1'b1; tick();
    chk("R1", "dx idle", int'(dx_o), 0);

    for (int v = 0; v < NV; v++) begin
      logic [18:0] e;
      e = VEC[v];
      run_case(e[18:11], int'(e[10:9]), e[8], int'(e[7:6]), int'(e[5:1]), e[0]);
    end

    // R7: error stays set, then host clear
    run_case(8'h81, 0, 1'b0, 0, 2, 1'b1);
    tick(); tick();
    chk("R7", "err sticky", int'(sync_err_o), 1);
    err_clr_i = 1'b1; tick(); err_clr_i = 1'b0;
    chk("R7", "err after clear", int'(sync_err_o), 0);

    // R11: disable mid-frame aborts frame and clears error
    run_case(8'hFF, 0, 1'b0, 0, 2, 1'b1);
    wr_en_i = 1'b1; wr_data_i = 8'hFF; tick(); wr_en_i = 1'b0;
    fs_i = 1'b1; tick(); fs_i = 1'b0;
    chk("R11", "dx mid-frame", int'(dx_o), 1);
    fs_i = 1'b1; tick(); fs_i = 1'b0;
    chk("R5", "err set mid-frame", int'(sync_err_o), 1);
    wr_en_i = 1'b1; wr_data_i = 8'h55; tick(); wr_en_i = 1'b0;
    tx_en_i = 1'b0; tick();
    chk("R11", "dx after disable", int'(dx_o), 0);
    chk("R11", "ready after disable", int'(ready_o), 1);
    chk("R11", "err after disable", int'(sync_err_o), 0);
    tx_en_i = 1'b1; tick();
    chk("R11", "dx stays idle", int'(dx_o), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule